// File: doc/BRIEF.md
# Packed Signed Halving Add/Subtract Unit

This unit is one execute-stage datapath slice. It takes a 32-bit instruction word and two 32-bit operand values, and it returns one packed 32-bit result one clock later. The 3-bit operation selector chooses how the operands are split. In halfword mode they are two signed 16-bit lanes. In byte mode they are four signed 8-bit lanes.

Each lane adds or subtracts its signed inputs at one bit more than the lane width. It then shifts that wider value right by one, arithmetically. The halved value always fits back in the lane, and it rounds toward negative infinity. Two halfword variants cross the lanes: the first operand's low half is paired with the second operand's high half, and one half adds while the other subtracts.

The unit also decodes the register-index fields, which the surrounding pipeline uses to read the register file. A small output state machine decides what each issued operation becomes:

- `ST_IDLE`: nothing was issued last cycle.
- `ST_WRITE`: the result is written to the destination.
- `ST_SKIP`: the condition failed, so nothing is written.
- `ST_FAULT`: a reserved selector was issued, so nothing is written and the illegal flag is raised.

The transitions are:

- Issue with a failed condition goes to `ST_SKIP`.
- Issue of a reserved selector with a passing condition goes to `ST_FAULT`.
- Issue of any other selector with a passing condition goes to `ST_WRITE`.
- A cycle with no issue goes to `ST_IDLE`.

Each state lasts exactly one cycle.

Top module: `psh_unit`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid`, `wr_en` and `illegal` are 0, and `result` and `dest_idx` are 0.
- R2: Selector 0 splits each operand into halfwords. Each result halfword is (a + b) >>> 1, computed on 17-bit signed values.
- R3: Selector 3 sets each result halfword to (a − b) >>> 1, using the matching halfwords of the two operands.
- R4: Selector 1 sets result[15:0] = (a[15:0] − b[31:16]) >>> 1 and result[31:16] = (a[31:16] + b[15:0]) >>> 1.
- R5: Selector 2 sets result[15:0] = (a[15:0] + b[31:16]) >>> 1 and result[31:16] = (a[31:16] − b[15:0]) >>> 1.
- R6: Selector 4 splits each operand into bytes. Result byte k (bits 8k+7:8k) is (a byte k + b byte k) >>> 1, computed on 9-bit signed values.
- R7: Selector 7 sets result byte k to (a byte k − b byte k) >>> 1.
- R8: Halving rounds toward negative infinity and never overflows. For example, 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000, and −1+0 gives −1.
- R9: The instruction fields sit at fixed positions:
  - condition in bits 31:28
  - family code in bits 21:20, shown on `fam_code`
  - first-operand register in bits 19:16, shown on `src_a_idx`
  - destination in bits 15:12
  - selector in bits 7:5
  - second-operand register in bits 3:0, shown on `src_b_idx`

  All three index outputs are combinational.
- R10: Condition 0xE always executes. Any other condition executes only when `cond_pass` is 1. A failed condition gives `out_valid`=1 with `wr_en`=0, and `result` keeps its previous value.
- R11: Selectors 5 and 6 are reserved. When one is issued with a passing condition, `illegal` is 1 for exactly that one response cycle and `wr_en` stays 0. `result` keeps its previous value.
- R12: `out_valid`, `wr_en`, `dest_idx` and `result` respond in the cycle after `in_valid`. Without `in_valid`, `out_valid`, `wr_en` and `illegal` are 0 in the next cycle. Issues may arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the current instruction |
| instr | input | 32 | Instruction word |
| opa | input | 32 | First operand value |
| opb | input | 32 | Second operand value |
| cond_pass | input | 1 | External condition evaluation result |
| src_a_idx | output | 4 | Decoded first-operand register index |
| src_b_idx | output | 4 | Decoded second-operand register index |
| fam_code | output | 2 | Decoded family code field |
| out_valid | output | 1 | A response is present this cycle |
| wr_en | output | 1 | Write the result to the destination |
| illegal | output | 1 | Reserved selector was issued |
| dest_idx | output | 4 | Registered destination register index |
| result | output | 32 | Registered packed result |

## Verification
The decoded index outputs are combinational. They are checked 1 ns after the instruction is driven, within the same cycle.

Every registered output (`out_valid`, `wr_en`, `illegal`, `dest_idx`, `result`) is due exactly one clock edge after the issue. The bench drives inputs on the falling edge. It predicts the next-cycle outputs with a behavioural model built from integer arithmetic, and compares them 1 ns after the following rising edge. Idle cycles are compared too. This makes a late, early or stuck response, or an `illegal` pulse lasting two cycles, show up as a mismatch.

// File: rtl/psh_pkg.sv
package psh_pkg;

    localparam int DATA_W   = 32;
    localparam int HALF_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int N_HALF   = DATA_W / HALF_W;
    localparam int N_BYTE   = DATA_W / BYTE_W;
    localparam int REG_W    = 4;
    localparam int COND_W   = 4;
    localparam int FAM_W    = 2;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

    typedef enum logic [2:0] {
        OP_H_ADD = 3'd0,
        OP_H_ASX = 3'd1,
        OP_H_SAX = 3'd2,
        OP_H_SUB = 3'd3,
        OP_B_ADD = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_B_SUB = 3'd7
    } psh_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_SKIP,
        ST_FAULT
    } psh_state_e;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [FAM_W-1:0]  fam;
        logic [REG_W-1:0]  rn;
        logic [REG_W-1:0]  rd;
        psh_op_e           sel;
        logic [REG_W-1:0]  rm;
    } psh_fields_t;

endpackage

// File: rtl/psh_decode.sv
module psh_decode
    import psh_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output psh_fields_t       fields
);
    logic unused_bits;

    always_comb begin
        fields.cond = instr[31:28];
        fields.fam  = instr[21:20];
        fields.rn   = instr[19:16];
        fields.rd   = instr[15:12];
        fields.sel  = psh_op_e'(instr[7:5]);
        fields.rm   = instr[3:0];
    end

    assign unused_bits = ^{instr[27:22], instr[11:8], instr[4]};
endmodule

// File: rtl/psh_lane.sv
module psh_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] q
);
    logic signed [W:0]   wide_a;
    logic signed [W:0]   wide_b;
    logic signed [W:0]   wide_r;
    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;
    logic signed [W-1:0] sq;
    logic                unused_lsb;

    always_comb begin
        wide_a = {a[W-1], a};
        wide_b = {b[W-1], b};
        wide_r = sub ? (wide_a - wide_b) : (wide_a + wide_b);
    end

    assign q          = wide_r[W:1];
    assign unused_lsb = wide_r[0];

    // Halved sum must lie between the two addends (no overflow, R8).
    always_comb begin
        sa = a;
        sb = b;
        sq = q;
        if (!sub) begin
            assert_add_bounded_R8: assert (((sq >= sa) || (sq >= sb)) && ((sq <= sa) || (sq <= sb)))
                else $error("halved sum outside operand range");
        end
    end
endmodule

// File: rtl/psh_datapath.sv
module psh_datapath
    import psh_pkg::*;
(
    input  psh_op_e           sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] packed_q
);
    logic              xchg;
    logic              byte_mode;
    logic [N_HALF-1:0] hsub;
    logic              bsub;
    logic [DATA_W-1:0] half_q;
    logic [DATA_W-1:0] byte_q;

    always_comb begin
        xchg      = (sel == OP_H_ASX) || (sel == OP_H_SAX);
        byte_mode = sel[2];
        hsub[0]   = (sel == OP_H_ASX) || (sel == OP_H_SUB);
        hsub[1]   = (sel == OP_H_SAX) || (sel == OP_H_SUB);
        bsub      = (sel == OP_B_SUB);
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        logic [HALF_W-1:0] b_pick;
        assign b_pick = xchg ? b[HALF_W*(N_HALF-1-h) +: HALF_W] : b[HALF_W*h +: HALF_W];
        psh_lane #(.W(HALF_W)) u_lane (
            .a   (a[HALF_W*h +: HALF_W]),
            .b   (b_pick),
            .sub (hsub[h]),
            .q   (half_q[HALF_W*h +: HALF_W])
        );
    end

    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        psh_lane #(.W(BYTE_W)) u_lane (
            .a   (a[BYTE_W*k +: BYTE_W]),
            .b   (b[BYTE_W*k +: BYTE_W]),
            .sub (bsub),
            .q   (byte_q[BYTE_W*k +: BYTE_W])
        );
    end

    assign packed_q = byte_mode ? byte_q : half_q;
endmodule

// File: rtl/psh_unit.sv
module psh_unit
    import psh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic        cond_pass,
    output logic [3:0]  src_a_idx,
    output logic [3:0]  src_b_idx,
    output logic [1:0]  fam_code,
    output logic        out_valid,
    output logic        wr_en,
    output logic        illegal,
    output logic [3:0]  dest_idx,
    output logic [31:0] result
);
    psh_fields_t       fld;
    psh_state_e        state_q;
    psh_state_e        state_d;
    logic [DATA_W-1:0] calc;
    logic [DATA_W-1:0] result_q;
    logic [REG_W-1:0]  dest_q;
    logic              exec;
    logic              reserved;

    psh_decode u_decode (
        .instr  (instr),
        .fields (fld)
    );

    psh_datapath u_datapath (
        .sel      (fld.sel),
        .a        (opa),
        .b        (opb),
        .packed_q (calc)
    );

    assign src_a_idx = fld.rn;
    assign src_b_idx = fld.rm;
    assign fam_code  = fld.fam;

    always_comb begin
        exec     = (fld.cond == COND_ALWAYS) || cond_pass;
        reserved = (fld.sel == OP_RSV5) || (fld.sel == OP_RSV6);
        state_d  = ST_IDLE;
        if (in_valid) begin
            if (!exec)         state_d = ST_SKIP;
            else if (reserved) state_d = ST_FAULT;
            else               state_d = ST_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
            dest_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) dest_q <= fld.rd;
            if (state_d == ST_WRITE) result_q <= calc;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        wr_en     = 1'b0;
        illegal   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: begin out_valid = 1'b1; wr_en   = 1'b1; end
            ST_SKIP:  out_valid = 1'b1;
            ST_FAULT: begin out_valid = 1'b1; illegal = 1'b1; end
            default:  ;
        endcase
    end

    assign result   = result_q;
    assign dest_idx = dest_q;

    assert_issue_before_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    assert_idle_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_reserved_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exec && reserved) |=> (illegal && !wr_en));
    assert_write_fault_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && illegal));
    assert_cond_fail_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !exec) |=> (out_valid && !wr_en && !illegal && $stable(result)));
    assert_always_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fld.cond == COND_ALWAYS) |=> (out_valid && (wr_en || illegal)));
endmodule

// File: tb/test_psh_unit.sv
`timescale 1ns/1ps
module test_psh_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr, opa, opb;
    logic        cond_pass;
    logic [3:0]  src_a_idx, src_b_idx, dest_idx;
    logic [1:0]  fam_code;
    logic        out_valid, wr_en, illegal;
    logic [31:0] result;

    always #2 clk = ~clk;

    psh_unit i_psh_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb), .cond_pass(cond_pass),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .fam_code(fam_code),
        .out_valid(out_valid), .wr_en(wr_en), .illegal(illegal),
        .dest_idx(dest_idx), .result(result)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        m_valid, m_wr, m_ill;
    logic [31:0] m_res;
    logic [3:0]  m_dst;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_op(int sel, logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        int al, ah, bl, bh, x, y, t;
        al = int'($signed(a[15:0]));  ah = int'($signed(a[31:16]));
        bl = int'($signed(b[15:0]));  bh = int'($signed(b[31:16]));
        case (sel)
            0: begin t = (al + bl) >>> 1; r[15:0] = t[15:0]; t = (ah + bh) >>> 1; r[31:16] = t[15:0]; end
            1: begin t = (al - bh) >>> 1; r[15:0] = t[15:0]; t = (ah + bl) >>> 1; r[31:16] = t[15:0]; end
            2: begin t = (al + bh) >>> 1; r[15:0] = t[15:0]; t = (ah - bl) >>> 1; r[31:16] = t[15:0]; end
            3: begin t = (al - bl) >>> 1; r[15:0] = t[15:0]; t = (ah - bh) >>> 1; r[31:16] = t[15:0]; end
            4, 7: begin
                for (int k = 0; k < 4; k++) begin
                    x = int'($signed(a[8*k +: 8]));
                    y = int'($signed(b[8*k +: 8]));
                    t = (sel == 4) ? ((x + y) >>> 1) : ((x - y) >>> 1);
                    r[8*k +: 8] = t[7:0];
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // One cycle: drive at falling edge, predict, compare after the next rising edge.
    task automatic step(string tag, bit v, logic [3:0] cond, int sel, logic [3:0] rn,
                        logic [3:0] rd, logic [3:0] rm, logic [31:0] a, logic [31:0] b, bit cp);
        logic [1:0] fam;
        fam = rn[1:0] ^ rd[1:0];
        in_valid  = v;
        instr     = {cond, 6'b101101, fam, rn, rd, 4'hA, sel[2:0], 1'b1, rm};
        opa       = a;
        opb       = b;
        cond_pass = cp;
        #1;
        chk("R9", "src_a_idx", {28'd0, src_a_idx}, {28'd0, rn});
        chk("R9", "src_b_idx", {28'd0, src_b_idx}, {28'd0, rm});
        chk("R9", "fam_code",  {30'd0, fam_code},  {30'd0, fam});
        if (v) begin
            m_valid = 1'b1;
            m_dst   = rd;
            if (!(cond == 4'hE || cp)) begin
                m_wr = 1'b0; m_ill = 1'b0;
            end else if (sel == 5 || sel == 6) begin
                m_wr = 1'b0; m_ill = 1'b1;
            end else begin
                m_wr = 1'b1; m_ill = 1'b0; m_res = ref_op(sel, a, b);
            end
        end else begin
            m_valid = 1'b0; m_wr = 1'b0; m_ill = 1'b0;
        end
        @(posedge clk);
        #1;
        chk(tag, "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
        chk(tag, "wr_en",     {31'd0, wr_en},     {31'd0, m_wr});
        chk(tag, "illegal",   {31'd0, illegal},   {31'd0, m_ill});
        chk(tag, "dest_idx",  {28'd0, dest_idx},  {28'd0, m_dst});
        chk(tag, "result",    result,             m_res);
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 4'hE, 0, 4'h0, m_dst, 4'h0, 32'h0, 32'h0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; instr = '0; opa = '0; opb = '0; cond_pass = 1'b0;
        m_valid = 1'b0; m_wr = 1'b0; m_ill = 1'b0; m_res = '0; m_dst = '0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "wr_en",     {31'd0, wr_en},     32'd0);
        chk("R1", "illegal",   {31'd0, illegal},   32'd0);
        chk("R1", "result",    result,             32'd0);
        rst_n = 1'b1;
        idle("R1");

        step("R2", 1, 4'hE, 0, 4'h1, 4'h2, 4'h3, 32'h0003_0005, 32'h0001_0003, 0);
        step("R2", 1, 4'hE, 0, 4'h4, 4'h5, 4'h6, 32'h1234_F000, 32'h0100_0FFF, 0);
        step("R3", 1, 4'hE, 3, 4'h7, 4'h8, 4'h9, 32'h0010_0001, 32'h0020_0004, 0);
        step("R4", 1, 4'hE, 1, 4'hA, 4'hB, 4'hC, 32'h0100_0050, 32'h0010_0030, 0);
        step("R5", 1, 4'hE, 2, 4'hD, 4'hE, 4'hF, 32'h0100_0050, 32'h0010_0030, 0);
        step("R6", 1, 4'hE, 4, 4'h1, 4'h3, 4'h5, 32'h7F80_FF01, 32'h7F80_0103, 0);
        step("R7", 1, 4'hE, 7, 4'h2, 4'h4, 4'h6, 32'h8001_7F10, 32'h7F02_8020, 0);
        step("R8", 1, 4'hE, 0, 4'h0, 4'h1, 4'h2, 32'h7FFF_8000, 32'h7FFF_8000, 0);
        step("R8", 1, 4'hE, 0, 4'h0, 4'h1, 4'h2, 32'hFFFF_0001, 32'h0000_0000, 0);
        step("R8", 1, 4'hE, 3, 4'h0, 4'h1, 4'h2, 32'h8000_7FFF, 32'h7FFF_8000, 0);
        step("R8", 1, 4'hE, 7, 4'h0, 4'h1, 4'h2, 32'h807F_FF00, 32'h7F80_0001, 0);
        idle("R12");
        step("R10", 1, 4'h0, 0, 4'h3, 4'h9, 4'h4, 32'h1111_1111, 32'h2222_2222, 0);
        step("R10", 1, 4'h1, 4, 4'h3, 4'h8, 4'h4, 32'h1111_1111, 32'h2222_2222, 1);
        step("R10", 1, 4'hE, 3, 4'h3, 4'h7, 4'h4, 32'h5555_0000, 32'h1111_2222, 0);
        step("R11", 1, 4'hE, 5, 4'h6, 4'h6, 4'h6, 32'hDEAD_BEEF, 32'h0BAD_F00D, 0);
        idle("R11");
        step("R11", 1, 4'h2, 6, 4'h6, 4'h5, 4'h6, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1);
        step("R11", 1, 4'h2, 6, 4'h6, 4'h5, 4'h6, 32'hDEAD_BEEF, 32'h0BAD_F00D, 0);
        step("R12", 1, 4'hE, 2, 4'h1, 4'hC, 4'h2, 32'hABCD_0123, 32'h4567_89AB, 0);
        idle("R12");
        idle("R12");
        for (int i = 1; i < 60; i++) begin
            logic [31:0] a, b;
            int s;
            a = 32'h9E37_79B9 * i;
            b = 32'h85EB_CA6B ^ (a << 3);
            s = (i * 5) % 8;
            step("R12", (i % 7) != 0, (i % 4 == 0) ? 4'h3 : 4'hE, s, a[3:0], b[7:4], a[11:8], a, b, i[0]);
        end
        idle("R12");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule